// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the execute stage of a small 16-bit accumulator-style processor. It takes an opcode, a destination operand and a second operand (a source value, or a shift count for shifts). In the same cycle it returns the result word, a write-back enable, the candidate next values of four condition flags, and a mask that marks which of those flags the instruction updates. Operand fetch, addressing, memory, multiply and divide are handled elsewhere and are not part of this block.

The four flags live in a register inside the block. On any cycle in which the execute strobe is high, the register loads the candidate value for each flag whose mask bit is set, and every other flag keeps its value. The flag register always presents bit 0 = carry, bit 1 = zero, bit 2 = sign and bit 3 = overflow, and `flag_nxt_o` and `flag_upd_o` use the same layout. The zero flag is set when the result is zero, and the sign flag is the result's top bit.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is 0. Flag bit layout: [0] carry, [1] zero, [2] sign, [3] overflow. Zero is (result == 0) and sign is result[15].
- R2: Opcodes: move 0x01, add 0x02, subtract 0x03, and 0x04, or 0x05, shift-left 0x06, shift-right 0x07, test 0x0B, compare 0x0C, negate 0x19, not 0x1D. Any other code gives `wb_o`=0, `flag_upd_o`=0 and `res_o`=`dst_i`.
- R3: Move gives `res_o`=`src_i`. Not gives `res_o`=~`dst_i`. Both give `wb_o`=1 and `flag_upd_o`=0.
- R4: Add gives dst+src modulo 2^16. Carry is the unsigned carry out. Overflow is set when the signed sum falls outside [-32768, 32767]. The mask covers all four flags, and `wb_o`=1.
- R5: Subtract gives dst-src. Carry is set when dst < src (unsigned borrow). Overflow is set when the signed difference falls outside the signed range. The mask covers all four flags, and `wb_o`=1.
- R6: Compare produces the same result and flags as subtract, with `wb_o`=0.
- R7: And and or give the bitwise result with carry=0 and overflow=0, zero and sign taken from the result, all four mask bits set and `wb_o`=1.
- R8: Test produces the same result and flags as and, with `wb_o`=0.
- R9: For shift counts from 1 to 15, shift-left and shift-right fill the vacated bits with zeros. Carry is the last bit shifted out (the top end for left, the bottom end for right). Overflow is set when result[15] differs from dst[15]. The mask is 4'b1001, and `wb_o`=1.
- R10: A shift count of 0 gives `res_o`=`dst_i` and a mask of 0. A count of 16 gives result 0, with carry = dst[0] for left and dst[15] for right. Any count above 16 gives result 0 and carry 0.
- R11: Negate gives 0-dst, with carry = (dst != 0) and all four mask bits set. Negating 0x8000 gives 0x8000 and sets overflow. Every other value gives overflow 0.
- R12: `flags_o` changes only after a rising clock edge at which `exec_i`=1. At that edge, the flags marked in `flag_upd_o` take their `flag_nxt_o` values and the other flags keep theirs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe that loads the flag register |
| op_i | input | OP_W (5) | Opcode |
| dst_i | input | DATA_W (16) | Destination operand |
| src_i | input | DATA_W (16) | Source operand or shift count |
| res_o | output | DATA_W (16) | Result word |
| wb_o | output | 1 | Write the result back to the destination |
| flag_nxt_o | output | 4 | Candidate flag values |
| flag_upd_o | output | 4 | Mask of the flags this opcode updates |
| flags_o | output | 4 | Registered flags |

## Verification
Additions are tried with operands at the signed and unsigned wrap points, such as 0x7FFF+1 and 0xFFFF+1, so that carry and overflow are seen to move independently. Subtractions and compares use operand pairs on both sides of the borrow point and across opposite signs. Shifts are tried with counts of 0, 1, mid-range, 15, 16 and above 16, which separates the zero-count hold, the last-bit carry and the saturation-to-zero cases. Negate is tried with zero, one and the minimum negative value. Long mixed runs with the strobe sometimes low confirm that each flag keeps its value whenever an opcode leaves it out of the mask.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned NFLAG = 4;
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_S = 2;
  localparam int unsigned FLG_V = 3;

  localparam int unsigned OPC_MOV  = 'h01;
  localparam int unsigned OPC_ADD  = 'h02;
  localparam int unsigned OPC_SUB  = 'h03;
  localparam int unsigned OPC_AND  = 'h04;
  localparam int unsigned OPC_OR   = 'h05;
  localparam int unsigned OPC_SHL  = 'h06;
  localparam int unsigned OPC_SHR  = 'h07;
  localparam int unsigned OPC_TEST = 'h0B;
  localparam int unsigned OPC_CMP  = 'h0C;
  localparam int unsigned OPC_NEG  = 'h19;
  localparam int unsigned OPC_NOT  = 'h1D;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] ext;

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
    else       ext = {1'b0, a_i} + {1'b0, b_i};
    res_o   = ext[DATA_W-1:0];
    carry_o = ext[DATA_W];   // carry out, or borrow for subtract
    if (sub_i) ovf_o = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
    else       ovf_o = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              active_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  logic                  over;
  logic [CNT_W-1:0]      amt;
  logic [2*DATA_W-1:0]   ext;

  always_comb begin
    over     = cnt_i > DATA_W'(DATA_W);
    amt      = over ? '0 : cnt_i[CNT_W-1:0];
    active_o = |cnt_i;
    if (left_i) begin
      ext     = {{DATA_W{1'b0}}, dst_i} << amt;
      res_o   = ext[DATA_W-1:0];
      carry_o = ext[DATA_W];
    end else begin
      ext     = {dst_i, {DATA_W{1'b0}}} >> amt;
      res_o   = ext[2*DATA_W-1:DATA_W];
      carry_o = ext[DATA_W-1];
    end
    if (over) begin
      res_o   = '0;
      carry_o = 1'b0;
    end
    ovf_o = res_o[DATA_W-1] ^ dst_i[DATA_W-1];
  end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg #(
  parameter int unsigned NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] mask_i,
  input  logic [NF-1:0] nxt_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[g] <= 1'b0;
      else if (en_i && mask_i[g]) q_o[g] <= nxt_i[g];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wb_o,
  output logic [NFLAG-1:0]  flag_nxt_o,
  output logic [NFLAG-1:0]  flag_upd_o,
  output logic [NFLAG-1:0]  flags_o
);
  localparam logic [OP_W-1:0]  OP_MOV  = OP_W'(OPC_MOV);
  localparam logic [OP_W-1:0]  OP_ADD  = OP_W'(OPC_ADD);
  localparam logic [OP_W-1:0]  OP_SUB  = OP_W'(OPC_SUB);
  localparam logic [OP_W-1:0]  OP_AND  = OP_W'(OPC_AND);
  localparam logic [OP_W-1:0]  OP_OR   = OP_W'(OPC_OR);
  localparam logic [OP_W-1:0]  OP_SHL  = OP_W'(OPC_SHL);
  localparam logic [OP_W-1:0]  OP_SHR  = OP_W'(OPC_SHR);
  localparam logic [OP_W-1:0]  OP_TEST = OP_W'(OPC_TEST);
  localparam logic [OP_W-1:0]  OP_CMP  = OP_W'(OPC_CMP);
  localparam logic [OP_W-1:0]  OP_NEG  = OP_W'(OPC_NEG);
  localparam logic [OP_W-1:0]  OP_NOT  = OP_W'(OPC_NOT);
  localparam logic [NFLAG-1:0] M_ALL   = '1;
  localparam logic [NFLAG-1:0] M_SHIFT = NFLAG'((1 << FLG_C) | (1 << FLG_V));

  logic              is_neg;
  logic [DATA_W-1:0] as_a, as_b, as_res, sh_res;
  logic              as_c, as_v, sh_c, sh_v, sh_act;
  logic              c_n, v_n;

  assign is_neg = (op_i == OP_NEG);
  assign as_a   = is_neg ? '0 : dst_i;
  assign as_b   = is_neg ? dst_i : src_i;

  acc_alu_addsub #(.DATA_W(DATA_W)) addsub_i (
    .a_i     (as_a),
    .b_i     (as_b),
    .sub_i   (op_i != OP_ADD),
    .res_o   (as_res),
    .carry_o (as_c),
    .ovf_o   (as_v)
  );

  acc_alu_shift #(.DATA_W(DATA_W)) shift_i (
    .dst_i    (dst_i),
    .cnt_i    (src_i),
    .left_i   (op_i == OP_SHL),
    .res_o    (sh_res),
    .carry_o  (sh_c),
    .ovf_o    (sh_v),
    .active_o (sh_act)
  );

  always_comb begin
    res_o      = dst_i;
    wb_o       = 1'b0;
    c_n        = 1'b0;
    v_n        = 1'b0;
    flag_upd_o = '0;
    case (op_i)
      OP_MOV: begin
        res_o = src_i;
        wb_o  = 1'b1;
      end
      OP_NOT: begin
        res_o = ~dst_i;
        wb_o  = 1'b1;
      end
      OP_ADD, OP_SUB, OP_NEG: begin
        res_o      = as_res;
        wb_o       = 1'b1;
        c_n        = as_c;
        v_n        = as_v;
        flag_upd_o = M_ALL;
      end
      OP_CMP: begin
        res_o      = as_res;
        c_n        = as_c;
        v_n        = as_v;
        flag_upd_o = M_ALL;
      end
      OP_AND, OP_TEST: begin
        res_o      = dst_i & src_i;
        wb_o       = (op_i == OP_AND);
        flag_upd_o = M_ALL;
      end
      OP_OR: begin
        res_o      = dst_i | src_i;
        wb_o       = 1'b1;
        flag_upd_o = M_ALL;
      end
      OP_SHL, OP_SHR: begin
        res_o      = sh_res;
        wb_o       = 1'b1;
        c_n        = sh_c;
        v_n        = sh_v;
        flag_upd_o = sh_act ? M_SHIFT : '0;
      end
      default: ;
    endcase
    flag_nxt_o        = '0;
    flag_nxt_o[FLG_C] = c_n;
    flag_nxt_o[FLG_Z] = (res_o == '0);
    flag_nxt_o[FLG_S] = res_o[DATA_W-1];
    flag_nxt_o[FLG_V] = v_n;
  end

  acc_alu_flagreg #(.NF(NFLAG)) flagreg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (exec_i),
    .mask_i (flag_upd_o),
    .nxt_i  (flag_nxt_o),
    .q_o    (flags_o)
  );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wb_o,
  input logic [NFLAG-1:0]  flag_nxt_o,
  input logic [NFLAG-1:0]  flag_upd_o,
  input logic [NFLAG-1:0]  flags_o
);
  // R5
  sub_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(OPC_SUB)) |-> (flag_nxt_o[FLG_C] == (dst_i < src_i)));

  // R6
  cmp_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(OPC_CMP) || op_i == OP_W'(OPC_TEST)) |-> !wb_o);

  // R7
  logic_cv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(OPC_AND) || op_i == OP_W'(OPC_OR) || op_i == OP_W'(OPC_TEST))
    |-> (!flag_nxt_o[FLG_C] && !flag_nxt_o[FLG_V]));

  // R9
  shift_zs_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(OPC_SHL) || op_i == OP_W'(OPC_SHR))
    |-> (!flag_upd_o[FLG_Z] && !flag_upd_o[FLG_S]));

  // R11
  neg_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(OPC_NEG)) |-> (flag_nxt_o[FLG_C] == (dst_i != '0)));

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(flags_o));

  // R12
  no_mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && flag_upd_o == '0) |=> $stable(flags_o));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .exec_i     (exec_i),
  .op_i       (op_i),
  .dst_i      (dst_i),
  .src_i      (src_i),
  .res_o      (res_o),
  .wb_o       (wb_o),
  .flag_nxt_o (flag_nxt_o),
  .flag_upd_o (flag_upd_o),
  .flags_o    (flags_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exec_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [15:0] dst_i = '0;
  logic [15:0] src_i = '0;
  logic [15:0] res_o;
  logic        wb_o;
  logic [3:0]  flag_nxt_o, flag_upd_o, flags_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [3:0] m_flags = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk_i = ~clk_i;

  acc_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .res_o(res_o), .wb_o(wb_o),
    .flag_nxt_o(flag_nxt_o), .flag_upd_o(flag_upd_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op, input logic [15:0] s);
    case (op)
      5'h01, 5'h1D: return "R3";
      5'h02: return "R4";
      5'h03: return "R5";
      5'h0C: return "R6";
      5'h04, 5'h05: return "R7";
      5'h0B: return "R8";
      5'h06, 5'h07: return (s == 0 || s >= 16) ? "R10" : "R9";
      5'h19: return "R11";
      default: return "R2";
    endcase
  endfunction

  // Behavioural reference: integer arithmetic, bitwise shift loop
  task automatic model(input logic [4:0] op, input logic [15:0] d, input logic [15:0] s,
                       output logic [15:0] r, output logic w,
                       output logic [3:0] nx, output logic [3:0] m);
    int sd, ss, t;
    logic c, v, outb;
    sd = int'($signed(d));
    ss = int'($signed(s));
    r = d; w = 0; c = 0; v = 0; m = 4'b0000;
    case (op)
      5'h01: begin r = s; w = 1; end
      5'h1D: begin r = ~d; w = 1; end
      5'h02: begin
        t = int'(d) + int'(s); r = t[15:0]; c = (t > 65535);
        v = (sd + ss > 32767) || (sd + ss < -32768); w = 1; m = 4'b1111;
      end
      5'h03, 5'h0C: begin
        t = int'(d) - int'(s); r = t[15:0]; c = (d < s);
        v = (sd - ss > 32767) || (sd - ss < -32768); w = (op == 5'h03); m = 4'b1111;
      end
      5'h19: begin
        t = 0 - int'(d); r = t[15:0]; c = (d != 0); v = (d == 16'h8000);
        w = 1; m = 4'b1111;
      end
      5'h04, 5'h0B: begin r = d & s; w = (op == 5'h04); m = 4'b1111; end
      5'h05: begin r = d | s; w = 1; m = 4'b1111; end
      5'h06, 5'h07: begin
        outb = 0;
        for (int i = 0; i < ((s > 40) ? 40 : int'(s)); i++) begin
          if (op == 5'h06) begin outb = r[15]; r = {r[14:0], 1'b0}; end
          else             begin outb = r[0];  r = {1'b0, r[15:1]}; end
        end
        c = outb; v = (r[15] != d[15]); w = 1;
        m = (s == 0) ? 4'b0000 : 4'b1001;
      end
      default: ;
    endcase
    nx = {v, r[15], (r == 16'h0), c};
  endtask

  task automatic step(input logic [4:0] op, input logic [15:0] d,
                      input logic [15:0] s, input bit ex);
    logic [15:0] er; logic ew; logic [3:0] en, em;
    string tg;
    @(negedge clk_i);
    check(flags_o == m_flags, "R12", "flags_o", flags_o, m_flags);
    op_i = op; dst_i = d; src_i = s; exec_i = ex;
    #1;
    model(op, d, s, er, ew, en, em);
    tg = tag_of(op, s);
    check(res_o == er, tg, "res_o", res_o, er);
    check(wb_o == ew, tg, "wb_o", wb_o, ew);
    check(flag_upd_o == em, tg, "flag_upd_o", flag_upd_o, em);
    check((flag_nxt_o & em) == (en & em), tg, "flag_nxt_o", flag_nxt_o & em, en & em);
    if (ex) m_flags = (m_flags & ~em) | (en & em);
  endtask

  initial begin
    logic [4:0] ops [12] = '{5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06,
                             5'h07, 5'h0B, 5'h0C, 5'h19, 5'h1D, 5'h08};
    repeat (3) @(posedge clk_i);
    #1 check(flags_o == 4'h0, "R1", "flags_o in reset", flags_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(5'h02, 16'h7FFF, 16'h0001, 1);   // R4 signed overflow
    step(5'h02, 16'hFFFF, 16'h0001, 1);   // R4 carry, zero
    step(5'h01, 16'h1234, 16'hABCD, 1);   // R3 flags held
    step(5'h1D, 16'h00FF, 16'h0000, 1);   // R3
    step(5'h03, 16'h0000, 16'h0001, 1);   // R5 borrow
    step(5'h03, 16'h8000, 16'h0001, 1);   // R5 overflow
    step(5'h0C, 16'h0005, 16'h0005, 1);   // R6 equal
    step(5'h0C, 16'h0003, 16'h0009, 1);   // R6
    step(5'h04, 16'hF0F0, 16'h0F0F, 1);   // R7 zero
    step(5'h05, 16'h8000, 16'h0001, 1);   // R7 sign
    step(5'h0B, 16'h8000, 16'hFFFF, 1);   // R8
    step(5'h06, 16'h8001, 16'h0001, 1);   // R9 carry out top
    step(5'h07, 16'h8001, 16'h0001, 1);   // R9 carry out bottom
    step(5'h06, 16'h4000, 16'h0001, 1);   // R9 overflow sign change
    step(5'h07, 16'h00F0, 16'h0005, 1);   // R9
    step(5'h06, 16'h0001, 16'h0010, 1);   // R10 count 16 left
    step(5'h07, 16'h8000, 16'h0010, 1);   // R10 count 16 right
    step(5'h06, 16'hFFFF, 16'h0011, 1);   // R10 count 17
    step(5'h07, 16'hFFFF, 16'h0100, 1);   // R10 large count
    step(5'h06, 16'hBEEF, 16'h0000, 1);   // R10 count 0
    step(5'h19, 16'h0000, 16'h0000, 1);   // R11 zero
    step(5'h19, 16'h8000, 16'h0000, 1);   // R11 minimum
    step(5'h19, 16'h0001, 16'h0000, 1);   // R11
    step(5'h08, 16'h5555, 16'hAAAA, 1);   // R2 unused code
    step(5'h1F, 16'h0000, 16'h0000, 1);   // R2 unused code
    step(5'h03, 16'h0000, 16'h0001, 0);   // R12 no strobe
    step(5'h01, 16'h0000, 16'h0000, 0);   // R12 settle

    for (int k = 0; k < 600; k++) begin
      logic [4:0] op;
      logic [15:0] s;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = ops[lfsr[3:0] % 12];
      s = lfsr[31:16];
      if ((op == 5'h06 || op == 5'h07) && lfsr[4]) s = {11'h0, lfsr[20:16]};
      step(op, lfsr[15:0] ^ {lfsr[7:0], lfsr[15:8]}, s, lfsr[5] | lfsr[6]);
    end
    step(5'h01, 16'h0000, 16'h0000, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule